// File: doc/BRIEF.md
# Card-Side Busy Signalling Responder

This block owns the card's data-out line during the busy period that follows a busy-type response on an SPI storage link. The card's operation logic raises a request to begin busy signalling just after such a response goes out. From then on, the block pulls data-out low whenever the host has the card selected. When the host deselects, the block lets go of the line. The busy condition is kept internally, so the host can come back at any time and see whether the card is still working.

All state changes happen on the rising edge of the serial clock. Chip select is sampled on that clock, so the line is released or taken again one clock after a chip-select edge. If no clock runs, the outputs hold their values.

When the internal busy flag clears, the block drives the line high to report completion. It keeps the line high until the host has seen that level and deselected the card. The block then goes back to idle and leaves the line in high impedance. High impedance is represented by a low output enable.

Top module: `busy_signal_responder`

## Requirements
- R1: Out of reset, the output enable is 0, the busy status flag is 0 and the data-out value is 1.
- R2: With the card selected, a busy-start request sampled while the internal busy flag is 1 makes the next clock show output enable 1, data-out 0 and busy status 1.
- R3: If chip select is sampled high while busy is being signalled, the next clock shows output enable 0 and busy status 0.
- R4: If chip select is sampled low again while the internal busy flag is still 1, the next clock shows output enable 1 and data-out 0.
- R5: Deselecting the card does not end the busy period: busy status returns on reselect, and while the card stays selected with busy asserted, busy status stays 1.
- R6: If the internal busy flag clears while the card is selected and signalling busy, the next clock shows output enable 1, data-out 1 and busy status 0.
- R7: If the internal busy flag clears while the card is deselected, the next reselect shows output enable 1 with data-out 1.
- R8: After the completion level has been shown to a selected host, a deselect returns the block to idle, so a later reselect leaves output enable at 0.
- R9: A busy-start request sampled while the internal busy flag is 0 is ignored, and output enable stays 0.
- R10: One clock after chip select is sampled high, output enable is 0, whatever the busy state.
- R11: While the serial clock is stopped, changes on chip select have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock from the host |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| busyIn | input | 1 | Internal busy flag from the card's operation logic |
| startBusy | input | 1 | Request to begin busy signalling after a response |
| doutVal | output | 1 | Value for the data-out line |
| doutEn | output | 1 | Output enable for data-out; 0 means high impedance |
| busySig | output | 1 | 1 while busy is being signalled on the line |

## Verification
A wrong phase register shows up on the line at the first clock on which the host has the card selected. A lost busy condition makes data-out high or floating where it should be low. A completion state that is missing or stuck makes output enable wrong on a later reselect. A wrong registered selection is visible exactly one clock after any chip-select edge, because output enable then fails to follow. Each scenario therefore samples the outputs one clock after every chip-select or busy-flag change, and again a few clocks later to catch a state that drifts.

// File: rtl/busy_resp_pkg.sv
package busy_resp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BUSY = 2'd1,
    PH_DONE = 2'd2
  } phase_t;

  typedef struct packed {
    logic busyOn;
    logic doneOn;
  } ctrl_strobe_t;

endpackage

// File: rtl/busy_resp_ctrl.sv
module busy_resp_ctrl
  import busy_resp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         selQ,
  input  logic         busyIn,
  input  logic         startBusy,
  output ctrl_strobe_t strobe
);

  phase_t phase;
  phase_t phaseNext;
  logic   beginReq;
  logic   hostSawDone;

  assign beginReq    = startBusy & busyIn;
  assign hostSawDone = selQ & csN;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (beginReq) phaseNext = PH_BUSY;
      PH_BUSY: if (!busyIn) phaseNext = PH_DONE;
      PH_DONE: begin
        if (beginReq)         phaseNext = PH_BUSY;
        else if (hostSawDone) phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign strobe.busyOn = (phase == PH_BUSY);
  assign strobe.doneOn = (phase == PH_DONE);

endmodule

// File: rtl/busy_resp_dp.sv
module busy_resp_dp
  import busy_resp_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  ctrl_strobe_t strobe,
  output logic         selQ,
  output logic         doutVal,
  output logic         doutEn,
  output logic         busySig
);

  logic driveReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selQ <= 1'b0;
    else       selQ <= ~csN;
  end

  assign driveReq = strobe.busyOn | strobe.doneOn;

  always_comb begin
    doutEn  = selQ & driveReq;
    doutVal = doutEn ? ~strobe.busyOn : IDLE_LEVEL;
    busySig = selQ & strobe.busyOn;
  end

endmodule

// File: rtl/busy_signal_responder.sv
module busy_signal_responder
  import busy_resp_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic busyIn,
  input  logic startBusy,
  output logic doutVal,
  output logic doutEn,
  output logic busySig
);

  ctrl_strobe_t strobe;
  logic         selQ;

  busy_resp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .selQ      (selQ),
    .busyIn    (busyIn),
    .startBusy (startBusy),
    .strobe    (strobe)
  );

  busy_resp_dp #(
    .IDLE_LEVEL (IDLE_LEVEL)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .strobe  (strobe),
    .selQ    (selQ),
    .doutVal (doutVal),
    .doutEn  (doutEn),
    .busySig (busySig)
  );

endmodule

// File: rtl/busy_signal_responder_chk.sv
module busy_signal_responder_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic busyIn,
  input logic doutVal,
  input logic doutEn,
  input logic busySig
);

  AST_BUSY_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    busySig |-> (doutEn && !doutVal)); // R2

  AST_RELEASE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    (busySig && busyIn && csN) |=> (!doutEn && !busySig)); // R3

  AST_BUSY_PERSISTS: assert property (@(posedge clk) disable iff (!rstN)
    (busySig && busyIn && !csN) |=> busySig); // R5

  AST_DONE_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (busySig && !busyIn && !csN) |=> (doutEn && doutVal && !busySig)); // R6

  AST_DESELECT_FLOATS: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !doutEn); // R10

endmodule

bind busy_signal_responder busy_signal_responder_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .busyIn  (busyIn),
  .doutVal (doutVal),
  .doutEn  (doutEn),
  .busySig (busySig)
);

// File: tb/busy_signal_responder_tb.sv
module busy_signal_responder_tb;

  logic clk = 1'b0;
  logic clkRun = 1'b1;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic busyIn = 1'b0;
  logic startBusy = 1'b0;
  logic doutVal, doutEn, busySig;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  busy_signal_responder u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .busyIn    (busyIn),
    .startBusy (startBusy),
    .doutVal   (doutVal),
    .doutEn    (doutEn),
    .busySig   (busySig)
  );

  // 50 MHz, gateable so a stopped clock can be exercised
  always begin
    #10;
    if (clkRun) clk = ~clk;
  end

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic expect3(string req, logic en, logic val, logic sig);
    nChecks++;
    if (doutEn !== en || doutVal !== val || busySig !== sig) begin
      nFails++;
      $display("FAIL %s: en/val/sig actual %b%b%b expected %b%b%b at %0t",
               req, doutEn, doutVal, busySig, en, val, sig, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; csN = 1'b1; busyIn = 1'b0; startBusy = 1'b0;
    cyc();
    cyc();
    rstN = 1'b1;
    cyc();
  endtask

  task automatic enterBusy();
    csN = 1'b0; busyIn = 1'b1; startBusy = 1'b1;
    cyc();
    startBusy = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0; csN = 1'b0;
    #3;
    expect3("R1", 1'b0, 1'b1, 1'b0);
    doReset();
    expect3("R1", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_start();
    doReset();
    csN = 1'b0;
    cyc();
    expect3("R9", 1'b0, 1'b1, 1'b0);
    startBusy = 1'b1; busyIn = 1'b0;
    cyc();
    startBusy = 1'b0;
    cyc();
    expect3("R9", 1'b0, 1'b1, 1'b0);
    busyIn = 1'b1; startBusy = 1'b1;
    cyc();
    startBusy = 1'b0;
    expect3("R2", 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) cyc();
    expect3("R5", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_deselect();
    doReset();
    enterBusy();
    csN = 1'b1;
    cyc();
    expect3("R3", 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) cyc();
    expect3("R10", 1'b0, 1'b1, 1'b0);
    csN = 1'b0;
    cyc();
    expect3("R4", 1'b1, 1'b0, 1'b1);
    cyc();
    expect3("R5", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_clearSelected();
    doReset();
    enterBusy();
    cyc();
    busyIn = 1'b0;
    cyc();
    expect3("R6", 1'b1, 1'b1, 1'b0);
    cyc();
    expect3("R6", 1'b1, 1'b1, 1'b0);
    csN = 1'b1;
    cyc();
    expect3("R10", 1'b0, 1'b1, 1'b0);
    csN = 1'b0;
    cyc();
    expect3("R8", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_clearDeselected();
    doReset();
    enterBusy();
    csN = 1'b1;
    cyc();
    busyIn = 1'b0;
    cyc();
    cyc();
    expect3("R10", 1'b0, 1'b1, 1'b0);
    csN = 1'b0;
    cyc();
    expect3("R7", 1'b1, 1'b1, 1'b0);
    csN = 1'b1;
    cyc();
    csN = 1'b0;
    cyc();
    expect3("R8", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_clockStop();
    doReset();
    enterBusy();
    cyc();
    @(negedge clk);
    #2;
    clkRun = 1'b0;
    csN = 1'b1;
    #200;
    expect3("R11", 1'b1, 1'b0, 1'b1);
    busyIn = 1'b0;
    #100;
    expect3("R11", 1'b1, 1'b0, 1'b1);
    busyIn = 1'b1;
    clkRun = 1'b1;
    cyc();
    expect3("R3", 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_start();
    t_deselect();
    t_clearSelected();
    t_clearDeselected();
    t_clockStop();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule